// File: doc/BRIEF.md
# Processor Status Flag Register

This block stores the arithmetic flags of a small processor core (zero, nibble carry and carry) next to two reset-cause bits. The reset-cause bits record whether a watchdog expiry happened and whether the core entered sleep. The ALU presents the flag values it computed, with one update enable per flag. An instruction that names this register as its destination presents a write strobe and a data byte. The watchdog and power logic pulse one-cycle event strobes.

The central rule covers an instruction that both writes the register and produces flags. The three flag bits of the written byte are then dropped. Every flag whose enable is set takes the computed value, and the rest keep their stored values. The reset-cause bits are never taken from written data. The carry and nibble-carry bits are stored exactly as the ALU delivers them: carry out of bit 7 and out of bit 3 on addition, and "no borrow" polarity (1 means no borrow) on subtraction.

The read-back byte puts the timeout flag at bit 4, the power-down flag at bit 3, zero at bit 2, nibble carry at bit 1 and carry at bit 0. Bits 7 to 5 always read 0.

Top module: `status_flags`

## Requirements
- R1: On power-on reset (rst_n low) the read-back value is 8'h18: bits 4 and 3 are 1, and bits 2, 1 and 0 are 0.
- R2: Read-back bits 7 to 5 are always 0, whatever data is written.
- R3: In a cycle where a flag's update enable is high, that flag (bit 2 zero, bit 1 nibble carry, bit 0 carry) takes the ALU value on the next clock edge.
- R4: When any of the three update enables is high in a write cycle, all three written flag bits are discarded. Flags whose enable is low keep their value. For example, writing 8'h00 with only the zero update (value 1) yields 000u u1uu.
- R5: A write with all three update enables low loads bits 2 to 0 from wr_data[2:0].
- R6: With no write and no update enable, the flags hold their value.
- R7: Bits 4 and 3 are never changed by writes; without event strobes they hold.
- R8: A watchdog-clear strobe sets both bit 4 and bit 3.
- R9: A sleep strobe sets bit 4 and clears bit 3.
- R10: A watchdog-expiry strobe clears bit 4, overriding clear and sleep strobes in the same cycle. It leaves bit 3 unaffected.
- R11: When sleep and watchdog-clear strobe in the same cycle, bit 3 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write by the current instruction |
| wr_data | input | 8 | Data written to the register |
| z_upd | input | 1 | Zero-flag update enable |
| dc_upd | input | 1 | Nibble-carry update enable |
| c_upd | input | 1 | Carry update enable |
| z_in | input | 1 | Computed zero flag |
| dc_in | input | 1 | Computed nibble carry / no-borrow |
| c_in | input | 1 | Computed carry / no-borrow |
| wdt_clr | input | 1 | Watchdog-clear event strobe |
| sleep_ev | input | 1 | Sleep-entry event strobe |
| wdt_expire | input | 1 | Watchdog-expiry event strobe |
| status | output | 8 | Read-back value |

## Verification
The hardest case to reach is a write that coincides with a partial flag update. In that case, flags without an enable must keep their old values rather than take the written data. Those old values must also differ from the data, or the two outcomes cannot be told apart. The bench therefore sweeps every combination of write strobe, written flag bits, enables, computed values and event strobes back to back. Each step inherits the state left by the previous one, so stored and written values differ in most steps.

// File: rtl/status_flags.sv
module status_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       z_upd,
  input  logic       dc_upd,
  input  logic       c_upd,
  input  logic       z_in,
  input  logic       dc_in,
  input  logic       c_in,
  input  logic       wdt_clr,
  input  logic       sleep_ev,
  input  logic       wdt_expire,
  output logic [7:0] status
);
  logic       to_q, pd_q;
  logic [2:0] flg_q, upd, alu, nxt;
  logic       take_wr;

  assign upd     = {z_upd, dc_upd, c_upd};
  assign alu     = {z_in, dc_in, c_in};
  assign take_wr = wr_en & ~|upd;

  always_comb
    for (int i = 0; i < 3; i++)
      nxt[i] = upd[i] ? alu[i] : (take_wr ? wr_data[i] : flg_q[i]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flg_q <= 3'b000;
      to_q  <= 1'b1;
      pd_q  <= 1'b1;
    end else begin
      flg_q <= nxt;
      if (wdt_expire)            to_q <= 1'b0;
      else if (wdt_clr | sleep_ev) to_q <= 1'b1;
      if (sleep_ev)              pd_q <= 1'b0;
      else if (wdt_clr)          pd_q <= 1'b1;
    end

  assign status = {3'b000, to_q, pd_q, flg_q};
endmodule

module status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       z_upd,
  input logic       dc_upd,
  input logic       c_upd,
  input logic       z_in,
  input logic       wdt_clr,
  input logic       sleep_ev,
  input logic       wdt_expire,
  input logic [7:0] status
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == 3'b000);
  a_r3_zero_update: assert property (@(posedge clk) disable iff (!rst_n)
    z_upd |=> status[2] == $past(z_in));
  a_r4_partial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !z_upd && (dc_upd || c_upd)) |=> $stable(status[2]));
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !z_upd && !dc_upd && !c_upd) |=> $stable(status[2:0]));
  a_r7_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_clr && !sleep_ev && !wdt_expire) |=> $stable(status[4:3]));
  a_r9_sleep_pd: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ev |=> !status[3]);
  a_r10_expire_to: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire |=> !status[4]);
endmodule

bind status_flags status_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .z_upd(z_upd), .dc_upd(dc_upd),
  .c_upd(c_upd), .z_in(z_in), .wdt_clr(wdt_clr), .sleep_ev(sleep_ev),
  .wdt_expire(wdt_expire), .status(status));

// File: tb/tb_status_flags.sv
module tb_status_flags;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       z_upd = 0, dc_upd = 0, c_upd = 0;
  logic       z_in = 0, dc_in = 0, c_in = 0;
  logic       wdt_clr = 0, sleep_ev = 0, wdt_expire = 0;
  logic [7:0] status;
  int total = 0, bad = 0;
  bit done = 0;
  logic [2:0] m_flg;
  logic m_to, m_pd;

  always #5 clk = ~clk;

  status_flags dut (.*);

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check(status, 8'h18, "R1");
    rst_n = 1;
    m_flg = 3'b000; m_to = 1; m_pd = 1;
    // R4: write of zero with only zero-flag update set -> 000u u1uu
    @(negedge clk);
    wr_en = 1; wr_data = 8'h07; @(negedge clk);
    m_flg = 3'b111;
    check(status, {3'b000, m_to, m_pd, m_flg}, "R5");
    wr_data = 8'h00; z_upd = 1; z_in = 1; @(negedge clk);
    wr_en = 0; z_upd = 0; z_in = 0;
    check(status, 8'h1f, "R4");
    for (int i = 0; i < 8192; i++) begin
      logic [2:0] d, u, a, ev;
      logic w;
      logic [2:0] ef;
      logic eto, epd;
      string ft, rt;
      w = i[0]; d = i[3:1]; u = i[6:4]; a = i[9:7]; ev = i[12:10];
      wr_en = w; wr_data = {i[5:1], d} ^ {i[12:8], 3'b000};
      {z_upd, dc_upd, c_upd} = u; {z_in, dc_in, c_in} = a;
      {wdt_clr, sleep_ev, wdt_expire} = ev;
      for (int b = 0; b < 3; b++)
        ef[b] = u[b] ? a[b] : ((w && u == 0) ? d[b] : m_flg[b]);
      eto = ev[0] ? 1'b0 : ((ev[2] | ev[1]) ? 1'b1 : m_to);
      epd = ev[1] ? 1'b0 : (ev[2] ? 1'b1 : m_pd);
      m_flg = ef; m_to = eto; m_pd = epd;
      ft = (u != 0) ? (w ? "R4" : "R3") : (w ? "R5" : "R6");
      rt = ev[0] ? "R10" : ((ev[2] && ev[1]) ? "R11" : (ev[1] ? "R9" : (ev[2] ? "R8" : "R7")));
      @(negedge clk);
      check({5'b0, status[2:0]}, {5'b0, ef}, ft);
      check({6'b0, status[4:3]}, {6'b0, eto, epd}, rt);
      check({5'b0, status[7:5]}, 8'h00, "R2");
    end
    wr_en = 0; {z_upd, dc_upd, c_upd} = 0; {wdt_clr, sleep_ev, wdt_expire} = 0;
    rst_n = 0; #1;
    check(status, 8'h18, "R1");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule